// File: doc/BRIEF.md
# Delayed Autocorrelation Frame Detector

This block finds the start of an OFDM burst by looking for a short preamble that repeats with period L. Complex baseband samples arrive on a valid/ready stream input. Each accepted sample updates two running sums over a sliding window that ends at that sample. The first is the correlation P between each sample and the conjugate of the sample one period later. The second is the energy R of the later half of the window. Both sums are kept recursively: the newest term is added and the term that leaves the window is subtracted. A delay line of twice the largest period supplies the samples that the recursion needs.

The detector compares the normalised metric |P|²/R² with a programmable fraction. A frame is declared once the metric has stayed above that fraction for a programmable number of consecutive samples. The output stream returns each sample unchanged, together with P, R and a one-sample frame flag. When the flag is set, the output also carries the index of the first sample of the run that met the threshold. A downstream frequency-offset stage takes P at the flagged sample. The period is chosen at run time from a small set of powers of two, so one instance serves several OFDM standards without a rebuild.

Top module: `afd_frame_detect`

## Requirements
- R1: The period is L = 8·2^k, where k is the `l_sel` code. With the default parameters, code 0 gives L=8, code 1 gives L=16, and codes 2 and 3 both give L=32. Moving between two codes that give the same L causes no restart.
- R2: For the output sample with index n, `m_p_re`/`m_p_im` equal the sum over m = 0..L-1 of r(d+m)·conj(r(d+m+L)), with d = n-2L+1. Here conj(b) negates the imaginary part, and any sample from before the last restart counts as zero.
- R3: For the output sample with index n, `m_energy` equals the sum over m = 0..L-1 of |r(d+m+L)|², with d = n-2L+1. Samples from before the last restart count as zero.
- R4: Sample n is above threshold when (|P|²·2^8) > `thr_frac`·R² and at least 2L samples have been accepted since the last restart, counting sample n.
- R5: `m_frame` is set on the sample at which the run of consecutive above-threshold samples reaches `hold_len`. A `hold_len` of 0 acts as 1. The flag fires once per run.
- R6: No frame can be flagged before 2L samples have entered after a restart.
- R7: A change of L restarts the block. In the clock cycle where L changes, `s_ready` is low. After it, the sums, the sample history, the run count and the sample index all start again from zero.
- R8: Each accepted input yields exactly one output, registered in the cycle of acceptance. While `m_valid` is high and `m_ready` is low, all outputs hold. `s_ready` is high when no change of L is pending and either the output slot is empty or it is being drained.
- R9: `m_re`/`m_im` carry the input sample unchanged.
- R10: With full-scale inputs (-2048 on both parts) at L=32, the sums are exact. P = 2^28 + 0j and R = 2^28.
- R11: After reset, `m_valid` is low and `s_ready` is high.
- R12: `m_start_idx` is the index of the first sample of the run that raised `m_frame`. Sample indices count from 0 after reset or a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_sel | input | 2 | Period code (R1) |
| thr_frac | input | 8 | Threshold fraction, in units of 1/256 |
| hold_len | input | 4 | Number of consecutive above-threshold samples needed |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high together with s_valid |
| s_re | input | 12 | Input real part, signed |
| s_im | input | 12 | Input imaginary part, signed |
| m_valid | output | 1 | Output valid |
| m_ready | input | 1 | Downstream ready |
| m_re | output | 12 | Forwarded real part |
| m_im | output | 12 | Forwarded imaginary part |
| m_p_re | output | 30 | Correlation P, real part, signed |
| m_p_im | output | 30 | Correlation P, imaginary part, signed |
| m_energy | output | 29 | Window energy R, unsigned |
| m_frame | output | 1 | Frame detected at this sample |
| m_start_idx | output | 16 | Index of the first sample of the detecting run |

## Verification
The recursion never recomputes its sums from scratch. A wrong term in the delay line or a missed clear therefore leaves a permanent offset in P or R. That offset appears on the very next output sample and on every output after it, until the next restart. A wrong tap choice for L only shows once samples older than L reach the window, so the bench switches periods and starts periodic patterns right after a restart. A fault in the run counter or in the gating shows in the exact sample at which `m_frame` rises and in the reported start index, so those are compared on every output.

// File: rtl/afd_pkg.sv
package afd_pkg;
    localparam int unsigned SMP_W = 12;

    typedef struct packed {
        logic signed [SMP_W-1:0] re;
        logic signed [SMP_W-1:0] im;
    } smp_t;
endpackage

// File: rtl/afd_delay_line.sv
module afd_delay_line
    import afd_pkg::*;
#(
    parameter int unsigned LMIN_LOG2 = 3,
    parameter int unsigned NUM_L     = 3,
    localparam int unsigned DEPTH    = 2 << (LMIN_LOG2 + NUM_L - 1),
    localparam int unsigned SW       = (NUM_L > 1) ? $clog2(NUM_L) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          shift_i,
    input  smp_t          din_i,
    input  logic [SW-1:0] sel_i,
    output smp_t          tap_l_o,
    output smp_t          tap_2l_o
);
    typedef struct packed {
        smp_t [DEPTH-1:0] line;
    } dl_st_t;

    dl_st_t st_q, st_d;

    // line[k] holds the sample accepted k+1 acceptances ago
    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (shift_i) begin
            st_d.line[0] = din_i;
            for (int k = 1; k < DEPTH; k++) begin
                st_d.line[k] = st_q.line[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    smp_t opt_l  [NUM_L];
    smp_t opt_2l [NUM_L];

    for (genvar g = 0; g < NUM_L; g++) begin : g_tap
        assign opt_l[g]  = st_q.line[(1 << (LMIN_LOG2 + g)) - 1];
        assign opt_2l[g] = st_q.line[(2 << (LMIN_LOG2 + g)) - 1];
    end

    always_comb begin
        tap_l_o  = opt_l[0];
        tap_2l_o = opt_2l[0];
        for (int g = 0; g < NUM_L; g++) begin
            if (sel_i == SW'(g)) begin
                tap_l_o  = opt_l[g];
                tap_2l_o = opt_2l[g];
            end
        end
    end
endmodule

// File: rtl/afd_corr_acc.sv
module afd_corr_acc
    import afd_pkg::*;
#(
    parameter int unsigned LMIN_LOG2 = 3,
    parameter int unsigned NUM_L     = 3,
    localparam int unsigned LMAX_LOG2 = LMIN_LOG2 + NUM_L - 1,
    localparam int unsigned PROD_W   = 2 * SMP_W + 1,
    localparam int unsigned PW       = PROD_W + LMAX_LOG2,
    localparam int unsigned RW       = 2 * SMP_W + LMAX_LOG2,
    localparam int unsigned SW       = (NUM_L > 1) ? $clog2(NUM_L) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 shift_i,
    input  smp_t                 din_i,
    input  smp_t                 tap_l_i,
    input  smp_t                 tap_2l_i,
    input  logic [SW-1:0]        sel_i,
    output logic signed [PW-1:0] p_re_o,
    output logic signed [PW-1:0] p_im_o,
    output logic [RW-1:0]        r_o
);
    typedef struct packed {
        logic signed [PW-1:0] p_re;
        logic signed [PW-1:0] p_im;
        logic [RW-1:0]        r;
    } acc_st_t;

    acc_st_t st_q, st_d;

    function automatic logic signed [PROD_W-1:0] sx(input logic signed [SMP_W-1:0] v);
        return PROD_W'(v);
    endfunction

    logic signed [PROD_W-1:0] in_re, in_im, out_re, out_im, e_in, e_out;

    always_comb begin
        // term entering: r(n-L) * conj(r(n))
        in_re  = sx(tap_l_i.re) * sx(din_i.re) + sx(tap_l_i.im) * sx(din_i.im);
        in_im  = sx(tap_l_i.im) * sx(din_i.re) - sx(tap_l_i.re) * sx(din_i.im);
        // term leaving: r(n-2L) * conj(r(n-L))
        out_re = sx(tap_2l_i.re) * sx(tap_l_i.re) + sx(tap_2l_i.im) * sx(tap_l_i.im);
        out_im = sx(tap_2l_i.im) * sx(tap_l_i.re) - sx(tap_2l_i.re) * sx(tap_l_i.im);
        e_in   = sx(din_i.re) * sx(din_i.re) + sx(din_i.im) * sx(din_i.im);
        e_out  = sx(tap_l_i.re) * sx(tap_l_i.re) + sx(tap_l_i.im) * sx(tap_l_i.im);

        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (shift_i) begin
            st_d.p_re = st_q.p_re + PW'(in_re) - PW'(out_re);
            st_d.p_im = st_q.p_im + PW'(in_im) - PW'(out_im);
            st_d.r    = st_q.r + RW'(unsigned'(e_in)) - RW'(unsigned'(e_out));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign p_re_o = st_d.p_re;
    assign p_im_o = st_d.p_im;
    assign r_o    = st_d.r;

    // largest possible window energy for the selected period
    logic [RW:0] r_bound;
    assign r_bound = (RW+1)'(1) << (2 * SMP_W - 1 + LMIN_LOG2 + 32'(sel_i));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.r} <= r_bound); // R10
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q == '0)); // R7
endmodule

// File: rtl/afd_detect.sv
module afd_detect #(
    parameter int unsigned TH_W   = 8,
    parameter int unsigned HOLD_W = 4,
    parameter int unsigned IDX_W  = 16,
    parameter int unsigned PW     = 30,
    parameter int unsigned RW     = 29,
    localparam int unsigned MW    = 2 * PW + TH_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 shift_i,
    input  logic signed [PW-1:0] p_re_i,
    input  logic signed [PW-1:0] p_im_i,
    input  logic [RW-1:0]        r_i,
    input  logic                 win_full_i,
    input  logic [TH_W-1:0]      thr_i,
    input  logic [HOLD_W-1:0]    hold_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic                 fire_o,
    output logic [IDX_W-1:0]     start_o
);
    typedef struct packed {
        logic [HOLD_W-1:0] run;
        logic [IDX_W-1:0]  start;
    } det_st_t;

    det_st_t st_q, st_d;

    logic signed [MW-1:0] pr_x, pi_x, mag;
    logic [MW-1:0]        lhs, rhs, r_x;
    logic                 above;
    logic [HOLD_W-1:0]    hold_eff;
    logic [HOLD_W:0]      run_inc;

    always_comb begin
        pr_x     = MW'(p_re_i);
        pi_x     = MW'(p_im_i);
        mag      = pr_x * pr_x + pi_x * pi_x;
        lhs      = unsigned'(mag) << TH_W;
        r_x      = MW'(r_i);
        rhs      = r_x * r_x * MW'(thr_i);
        above    = win_full_i && (lhs > rhs);
        hold_eff = (hold_i == '0) ? HOLD_W'(1) : hold_i;
        run_inc  = {1'b0, st_q.run} + (HOLD_W+1)'(1);

        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (shift_i) begin
            if (above) begin
                if (st_q.run == '0) st_d.start = idx_i;
                if (st_q.run != '1) st_d.run = run_inc[HOLD_W-1:0];
            end else begin
                st_d.run = '0;
            end
        end

        fire_o  = shift_i && !clear_i && above && (run_inc == {1'b0, hold_eff});
        start_o = (st_q.run == '0) ? idx_i : st_q.start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && $stable(hold_i)) |=> !fire_o); // R5
endmodule

// File: rtl/afd_frame_detect.sv
module afd_frame_detect
    import afd_pkg::*;
#(
    parameter int unsigned LMIN_LOG2 = 3,
    parameter int unsigned NUM_L     = 3,
    parameter int unsigned TH_W      = 8,
    parameter int unsigned HOLD_W    = 4,
    parameter int unsigned IDX_W     = 16,
    localparam int unsigned SW       = (NUM_L > 1) ? $clog2(NUM_L) : 1,
    localparam int unsigned LMAX_LOG2 = LMIN_LOG2 + NUM_L - 1,
    localparam int unsigned PW       = 2 * SMP_W + 1 + LMAX_LOG2,
    localparam int unsigned RW       = 2 * SMP_W + LMAX_LOG2,
    localparam int unsigned FILL_MAX = (2 << LMAX_LOG2) + (1 << HOLD_W),
    localparam int unsigned FW       = $clog2(FILL_MAX + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SW-1:0]           l_sel,
    input  logic [TH_W-1:0]         thr_frac,
    input  logic [HOLD_W-1:0]       hold_len,
    input  logic                    s_valid,
    output logic                    s_ready,
    input  logic signed [SMP_W-1:0] s_re,
    input  logic signed [SMP_W-1:0] s_im,
    output logic                    m_valid,
    input  logic                    m_ready,
    output logic signed [SMP_W-1:0] m_re,
    output logic signed [SMP_W-1:0] m_im,
    output logic signed [PW-1:0]    m_p_re,
    output logic signed [PW-1:0]    m_p_im,
    output logic [RW-1:0]           m_energy,
    output logic                    m_frame,
    output logic [IDX_W-1:0]        m_start_idx
);
    typedef struct packed {
        logic [SW-1:0]        sel;
        logic [FW-1:0]        fill;
        logic [IDX_W-1:0]     idx;
        logic                 ov;
        smp_t                 od;
        logic signed [PW-1:0] opre;
        logic signed [PW-1:0] opim;
        logic [RW-1:0]        oen;
        logic                 ofr;
        logic [IDX_W-1:0]     ostart;
    } top_st_t;

    top_st_t st_q, st_d;

    logic                 clear, accept, win_full, det_fire;
    logic [SW-1:0]        sel_eff;
    logic [FW:0]          two_l;
    smp_t                 din, tap_l, tap_2l;
    logic signed [PW-1:0] p_re_n, p_im_n;
    logic [RW-1:0]        r_n;
    logic [IDX_W-1:0]     det_start;

    always_comb begin
        sel_eff  = (l_sel > SW'(NUM_L - 1)) ? SW'(NUM_L - 1) : l_sel;
        clear    = (sel_eff != st_q.sel);
        s_ready  = !clear && (!st_q.ov || m_ready);
        accept   = s_valid && s_ready;
        din.re   = s_re;
        din.im   = s_im;
        two_l    = (FW+1)'(2) << (LMIN_LOG2 + 32'(st_q.sel));
        win_full = ({1'b0, st_q.fill} + (FW+1)'(1)) >= two_l;
    end

    afd_delay_line #(.LMIN_LOG2(LMIN_LOG2), .NUM_L(NUM_L)) i_dline (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .shift_i (accept),
        .din_i   (din),
        .sel_i   (st_q.sel),
        .tap_l_o (tap_l),
        .tap_2l_o(tap_2l)
    );

    afd_corr_acc #(.LMIN_LOG2(LMIN_LOG2), .NUM_L(NUM_L)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .shift_i (accept),
        .din_i   (din),
        .tap_l_i (tap_l),
        .tap_2l_i(tap_2l),
        .sel_i   (st_q.sel),
        .p_re_o  (p_re_n),
        .p_im_o  (p_im_n),
        .r_o     (r_n)
    );

    afd_detect #(.TH_W(TH_W), .HOLD_W(HOLD_W), .IDX_W(IDX_W), .PW(PW), .RW(RW)) i_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .shift_i   (accept),
        .p_re_i    (p_re_n),
        .p_im_i    (p_im_n),
        .r_i       (r_n),
        .win_full_i(win_full),
        .thr_i     (thr_frac),
        .hold_i    (hold_len),
        .idx_i     (st_q.idx),
        .fire_o    (det_fire),
        .start_o   (det_start)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_eff;
        if (clear) begin
            st_d.fill = '0;
            st_d.idx  = '0;
        end else if (accept) begin
            if (st_q.fill < FW'(FILL_MAX)) st_d.fill = st_q.fill + FW'(1);
            st_d.idx = st_q.idx + IDX_W'(1);
        end

        if (accept) begin
            st_d.ov     = 1'b1;
            st_d.od     = din;
            st_d.opre   = p_re_n;
            st_d.opim   = p_im_n;
            st_d.oen    = r_n;
            st_d.ofr    = det_fire;
            st_d.ostart = det_start;
        end else if (st_q.ov && m_ready) begin
            st_d.ov = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_valid     = st_q.ov;
    assign m_re        = st_q.od.re;
    assign m_im        = st_q.od.im;
    assign m_p_re      = st_q.opre;
    assign m_p_im      = st_q.opim;
    assign m_energy    = st_q.oen;
    assign m_frame     = st_q.ofr;
    assign m_start_idx = st_q.ostart;

    logic [FW:0] hold_ext;
    assign hold_ext = (hold_len == '0) ? (FW+1)'(1) : (FW+1)'(hold_len);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_re) && $stable(m_im)
            && $stable(m_p_re) && $stable(m_p_im) && $stable(m_frame))); // R8
    AST_NO_EARLY_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        det_fire |-> (({1'b0, st_q.fill} + (FW+1)'(1)) >= (two_l + hold_ext - (FW+1)'(1)))); // R6
endmodule

// File: tb/test_afd_frame_detect.sv
module test_afd_frame_detect;
    localparam int TH_W = 8;

    logic               clk;
    logic               rst_n;
    logic [1:0]         l_sel;
    logic [7:0]         thr_frac;
    logic [3:0]         hold_len;
    logic               s_valid, s_ready;
    logic signed [11:0] s_re, s_im;
    logic               m_valid, m_ready;
    logic signed [11:0] m_re, m_im;
    logic signed [29:0] m_p_re, m_p_im;
    logic [28:0]        m_energy;
    logic               m_frame;
    logic [15:0]        m_start_idx;

    afd_frame_detect i_afd_frame_detect (
        .clk(clk), .rst_n(rst_n), .l_sel(l_sel), .thr_frac(thr_frac), .hold_len(hold_len),
        .s_valid(s_valid), .s_ready(s_ready), .s_re(s_re), .s_im(s_im),
        .m_valid(m_valid), .m_ready(m_ready), .m_re(m_re), .m_im(m_im),
        .m_p_re(m_p_re), .m_p_im(m_p_im), .m_energy(m_energy),
        .m_frame(m_frame), .m_start_idx(m_start_idx)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int hre [0:1023];
    int him [0:1023];
    int hn = 0;
    int cur_l = 8;
    int run = 0;
    int start = 0;
    longint exp_pre, exp_pim, exp_r;
    bit exp_fire;
    int exp_start;
    int dut_frames, mdl_frames;
    int pat_re [0:31];
    int pat_im [0:31];

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic model_push(input int re, input int im);
        longint pr, pi, rr;
        longint unsigned mag;
        logic [95:0] lhs, rhs;
        bit above;
        int hold_eff;
        hre[hn] = re;
        him[hn] = im;
        pr = 0; pi = 0; rr = 0;
        for (int m = 0; m < cur_l; m++) begin
            int a;
            int b;
            longint ar, ai, br, bi;
            a = hn - 2 * cur_l + 1 + m;
            b = a + cur_l;
            ar = (a >= 0) ? longint'(hre[a]) : 0;
            ai = (a >= 0) ? longint'(him[a]) : 0;
            br = (b >= 0) ? longint'(hre[b]) : 0;
            bi = (b >= 0) ? longint'(him[b]) : 0;
            pr += ar * br + ai * bi;
            pi += ai * br - ar * bi;
            rr += br * br + bi * bi;
        end
        mag = longint'(pr * pr + pi * pi);
        lhs = 96'(mag) << TH_W;
        rhs = 96'(rr) * 96'(rr) * 96'(thr_frac);
        above = (hn + 1 >= 2 * cur_l) && (lhs > rhs);
        hold_eff = (hold_len == 0) ? 1 : int'(hold_len);
        exp_fire = above && (run + 1 == hold_eff);
        if (above) begin
            if (run == 0) start = hn;
            if (run < 15) run++;
        end else begin
            run = 0;
        end
        exp_pre = pr; exp_pim = pi; exp_r = rr; exp_start = start;
        if (exp_fire) mdl_frames++;
        hn++;
    endtask

    // starts and ends at a falling edge
    task automatic send(input int re, input int im, input bit bp);
        bit acc;
        bit held;
        logic signed [29:0] h_pre;
        logic signed [11:0] h_re;
        int idx_now;
        idx_now = hn;
        model_push(re, im);
        s_valid = 1'b1;
        s_re = 12'(re);
        s_im = 12'(im);
        acc = 0;
        for (int w = 0; w < 50 && !acc; w++) begin
            m_ready = bp ? 1'($urandom % 2) : 1'b1;
            #1;
            acc = s_ready;
            held = m_valid && !m_ready;
            h_pre = m_p_re;
            h_re = m_re;
            @(posedge clk);
            @(negedge clk);
            if (held) begin
                chk("R8 hold m_p_re", longint'(m_p_re), longint'(h_pre));
                chk("R8 hold m_re", longint'(m_re), longint'(h_re));
            end
        end
        s_valid = 1'b0;
        chk("R8 accepted", longint'(acc), 1);
        chk("R8 m_valid", longint'(m_valid), 1);
        chk("R9 m_re", longint'(m_re), longint'(re));
        chk("R9 m_im", longint'(m_im), longint'(im));
        chk("R2 m_p_re", longint'(m_p_re), exp_pre);
        chk("R2 m_p_im", longint'(m_p_im), exp_pim);
        chk("R3 m_energy", longint'(m_energy), exp_r);
        chk("R5 m_frame", longint'(m_frame), longint'(exp_fire));
        if (idx_now + 1 < 2 * cur_l) chk("R6 no early frame", longint'(m_frame), 0);
        if (exp_fire) chk("R12 m_start_idx", longint'(m_start_idx), longint'(exp_start));
        if (m_frame) dut_frames++;
    endtask

    task automatic set_mode(input logic [1:0] sel, input int thr, input int hold, input bit expect_clear);
        l_sel = sel;
        thr_frac = 8'(thr);
        hold_len = 4'(hold);
        m_ready = 1'b1;
        #1;
        chk("R7 s_ready during change", longint'(s_ready), expect_clear ? 0 : 1);
        @(posedge clk);
        @(negedge clk);
        if (expect_clear) begin
            hn = 0;
            run = 0;
            start = 0;
        end
        cur_l = 8 << ((sel > 2) ? 2 : int'(sel));
    endtask

    function automatic int rnd12();
        return int'($urandom % 4096) - 2048;
    endfunction

    task automatic make_pat(input int len);
        for (int i = 0; i < len; i++) begin
            pat_re[i] = rnd12();
            pat_im[i] = rnd12();
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; l_sel = 2'd0; thr_frac = 8'd160; hold_len = 4'd4;
        s_valid = 1'b0; s_re = '0; s_im = '0; m_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 m_valid after reset", longint'(m_valid), 0);
        chk("R11 s_ready after reset", longint'(s_ready), 1);
        @(negedge clk);

        // L=8: noise, then a repeating preamble, then noise
        dut_frames = 0; mdl_frames = 0;
        for (int i = 0; i < 16; i++) send(rnd12(), rnd12(), 0);
        make_pat(8);
        for (int i = 0; i < 48; i++) send(pat_re[i % 8], pat_im[i % 8], 0);
        for (int i = 0; i < 20; i++) send(rnd12(), rnd12(), 0);
        chk("R4 frames seen at L=8", longint'(dut_frames > 0), 1);
        chk("R5 frame count at L=8", longint'(dut_frames), longint'(mdl_frames));

        // L=16, hold 0 acts as 1, periodic from the first sample after restart
        set_mode(2'd1, 200, 0, 1);
        dut_frames = 0; mdl_frames = 0;
        make_pat(16);
        for (int i = 0; i < 48; i++) send(pat_re[i % 16], pat_im[i % 16], 0);
        for (int i = 0; i < 20; i++) send(rnd12(), rnd12(), 0);
        chk("R5 frame count at L=16", longint'(dut_frames), longint'(mdl_frames));

        // L=32 full scale
        set_mode(2'd2, 128, 3, 1);
        dut_frames = 0; mdl_frames = 0;
        for (int i = 0; i < 70; i++) begin
            send(-2048, -2048, 0);
            if (i == 63) begin
                chk("R10 full-scale p_re", longint'(m_p_re), 64'sd268435456);
                chk("R10 full-scale p_im", longint'(m_p_im), 0);
                chk("R10 full-scale energy", longint'(m_energy), 64'sd268435456);
            end
        end
        chk("R5 one frame full scale", longint'(dut_frames), 1);

        // code 3 gives the same period: R1 no restart; backpressure
        set_mode(2'd3, 128, 3, 0);
        make_pat(32);
        for (int i = 0; i < 30; i++) send(rnd12(), rnd12(), 1);
        for (int i = 0; i < 30; i++) send(pat_re[i % 32], pat_im[i % 32], 1);

        // back to L=8 with backpressure and a shorter hold
        set_mode(2'd0, 100, 2, 1);
        dut_frames = 0; mdl_frames = 0;
        make_pat(8);
        for (int i = 0; i < 40; i++) send(pat_re[i % 8], pat_im[i % 8], 1);
        for (int i = 0; i < 10; i++) send(rnd12(), rnd12(), 1);
        chk("R1 R5 frame count at L=8 again", longint'(dut_frames), longint'(mdl_frames));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule